// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the combinational execute stage of a classic 16-opcode data-processing instruction set. It takes the 4-bit opcode, a first operand, a second operand that has already passed through the shifter, the shifter's carry-out and the current N, Z, C, V flags. It returns the result word, a result-write enable, the next flags, and two indications for the surrounding core: a request to reload the status register from its saved copy, and a marker for the undefined compare-to-PC case.

Subtraction uses the no-borrow carry convention. Reverse-operand forms run on the same adder with the operands exchanged. Logic operations take carry from the shifter and keep V. The four test and compare opcodes always set flags and never write a result. A flag-setting write to register 15 asks for the saved status to be restored instead of computing flags.

Top module: `dp_alu`

## Requirements
- R1: Logic results follow the opcode: 0 gives a AND b, 1 gives a XOR b, 12 gives a OR b, 13 gives b, 14 gives a AND NOT b, 15 gives NOT b. Opcodes 8 and 9 compute a AND b and a XOR b for flags only.
- R2: Arithmetic results follow the opcode: 2 gives a-b, 3 gives b-a, 4 gives a+b, 5 gives a+b+C, 6 gives a-b-1+C, 7 gives b-a-1+C, all modulo 2^32. C is bit 1 of `flg_i`. Opcodes 10 and 11 compute a-b and a+b for flags only.
- R3: For an add-type opcode (4, 5, 11), the next C is the carry out of the full sum, including any carry-in. For a subtract-type opcode (2, 3, 6, 7, 10), the next C is 1 exactly when the value taken away, plus one minus the carry-in, does not exceed the minuend.
- R4: For arithmetic opcodes, the next V is 1 exactly when the result's sign is wrong for two's-complement overflow of the add or subtract performed.
- R5: Whenever flags are computed, N is result bit 31 and Z is 1 exactly when the result is zero. The flag vector is {N,Z,C,V}, with N in bit 3 and V in bit 0.
- R6: When flags are computed for a logic opcode (0, 1, 8, 9, 12-15), the next C equals `shc_i` and V is unchanged.
- R7: Opcodes 8-11 never assert `wr_en_o`, and they update flags whatever the value of `setf_i`. All other opcodes assert `wr_en_o`.
- R8: For a result-writing opcode with `setf_i` low, `flg_o` equals `flg_i`.
- R9: For a result-writing opcode with `setf_i` and `rd_pc_i` both high, `rstr_o` is 1, `flg_o` equals `flg_i`, and the result is still written.
- R10: For opcodes 8-11 with `rd_pc_i` high, `undef_o` is 1, `flg_o` equals `flg_i`, `rstr_o` is 0 and nothing is written.
- R11: In all other cases `rstr_o` and `undef_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opc_i | input | 4 | Data-processing opcode |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, already shifted |
| shc_i | input | 1 | Carry-out of the operand shifter |
| flg_i | input | 4 | Current flags {N,Z,C,V} |
| setf_i | input | 1 | Set-flags bit of the instruction |
| rd_pc_i | input | 1 | Destination register is 15 |
| res_o | output | 32 | Computed result |
| wr_en_o | output | 1 | Result should be written to the destination |
| flg_o | output | 4 | Next flags {N,Z,C,V} |
| rstr_o | output | 1 | Request to restore status from the saved copy |
| undef_o | output | 1 | Compare or test opcode aimed at register 15 |

## Verification
The hardest cases to reach are the carry and overflow edges of the carry-in forms. These are SBC and RSC with carry clear on equal operands, and ADC where only the added carry wraps the sum. Random operands almost never produce them. The stimulus therefore crosses the corner values 0, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and 1 against each other under every opcode, with both carry-in values. It then adds random operands and random destination and set-flags bits, so that the restore and undefined paths are reached for each opcode.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } opc_e;

  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FC = 1;
  localparam int FV = 0;

  function automatic logic op_is_test(logic [3:0] o);
    return o[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_arith(logic [3:0] o);
    return (o >= OP_SUB && o <= OP_RSC) || o == OP_CMP || o == OP_CMN;
  endfunction

  function automatic logic op_is_sub(logic [3:0] o);
    return o == OP_SUB || o == OP_RSB || o == OP_SBC || o == OP_RSC || o == OP_CMP;
  endfunction

  function automatic logic op_swaps(logic [3:0] o);
    return o == OP_RSB || o == OP_RSC;
  endfunction

  function automatic logic op_takes_cin(logic [3:0] o);
    return o == OP_ADC || o == OP_SBC || o == OP_RSC;
  endfunction
endpackage

// File: rtl/dp_alu_arith.sv
module dp_alu_arith #(
  parameter int W = 32
) (
  input  logic [3:0]   opc_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  import dp_alu_pkg::*;

  logic         sub_k, swap_k, ci;
  logic [W-1:0] x, y, y_eff;
  logic [W:0]   t;

  always_comb begin
    sub_k  = op_is_sub(opc_i);
    swap_k = op_swaps(opc_i);
    x      = swap_k ? b_i : a_i;
    y      = swap_k ? a_i : b_i;
    y_eff  = sub_k ? ~y : y;
    ci     = op_takes_cin(opc_i) ? cin_i : sub_k;
    t      = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, ci};
    sum_o  = t[W-1:0];
    c_o    = t[W];
    if (sub_k) v_o = (x[W-1] ^ sum_o[W-1]) & (~y[W-1] ^ sum_o[W-1]);
    else       v_o = (x[W-1] ^ sum_o[W-1]) & (y[W-1] ^ sum_o[W-1]);
  end

  // Add-type ops: a carry-out means the sum wrapped to at or below the minuend side
  always_comb begin
    if (!$isunknown({opc_i, a_i, b_i, cin_i}) && !sub_k) begin
      p_add_wrap_r3: assert (c_o ? (sum_o <= x) : (sum_o >= x))
        else $error("add carry inconsistent with wrap");
    end
  end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic #(
  parameter int W = 32
) (
  input  logic [3:0]   opc_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] r_o
);
  import dp_alu_pkg::*;

  always_comb begin
    unique case (opc_i)
      OP_AND, OP_TST: r_o = a_i & b_i;
      OP_EOR, OP_TEQ: r_o = a_i ^ b_i;
      OP_ORR:         r_o = a_i | b_i;
      OP_MOV:         r_o = b_i;
      OP_BIC:         r_o = a_i & ~b_i;
      OP_MVN:         r_o = ~b_i;
      default:        r_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags #(
  parameter int W = 32
) (
  input  logic [3:0]   opc_i,
  input  logic [W-1:0] res_i,
  input  logic         ac_i,
  input  logic         av_i,
  input  logic         shc_i,
  input  logic [3:0]   flg_i,
  input  logic         setf_i,
  input  logic         rd_pc_i,
  output logic [3:0]   flg_o,
  output logic         wr_en_o,
  output logic         rstr_o,
  output logic         undef_o
);
  import dp_alu_pkg::*;

  logic test_k, arith_k, calc_k, zero_k;

  always_comb begin
    test_k  = op_is_test(opc_i);
    arith_k = op_is_arith(opc_i);
    zero_k  = (res_i == '0);
    wr_en_o = !test_k;
    undef_o = test_k && rd_pc_i;
    rstr_o  = !test_k && setf_i && rd_pc_i;
    calc_k  = test_k ? !rd_pc_i : (setf_i && !rd_pc_i);
    flg_o   = flg_i;
    if (calc_k) begin
      flg_o[FN] = res_i[W-1];
      flg_o[FZ] = zero_k;
      flg_o[FC] = arith_k ? ac_i : shc_i;
      flg_o[FV] = arith_k ? av_i : flg_i[FV];
    end
  end

  always_comb begin
    if (!$isunknown({opc_i, setf_i, rd_pc_i, flg_i, shc_i})) begin
      p_test_nowrite_r7: assert (!(test_k && wr_en_o))
        else $error("compare op wrote result");
      p_hold_on_restore_r9: assert (!rstr_o || flg_o == flg_i)
        else $error("flags changed on restore");
      p_hold_on_undef_r10: assert (!undef_o || (flg_o == flg_i && !rstr_o))
        else $error("flags changed on undefined case");
      p_logic_keeps_v_r6: assert (!(calc_k && !arith_k) || (flg_o[FV] == flg_i[FV] && flg_o[FC] == shc_i))
        else $error("logic op touched V or lost shifter carry");
      p_hold_no_setf_r8: assert (!(!test_k && !setf_i) || flg_o == flg_i)
        else $error("flags changed with set-flags clear");
      p_excl_r11: assert (!(rstr_o && undef_o))
        else $error("restore and undefined both raised");
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int W = 32
) (
  input  logic [3:0]   opc_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         shc_i,
  input  logic [3:0]   flg_i,
  input  logic         setf_i,
  input  logic         rd_pc_i,
  output logic [W-1:0] res_o,
  output logic         wr_en_o,
  output logic [3:0]   flg_o,
  output logic         rstr_o,
  output logic         undef_o
);
  import dp_alu_pkg::*;

  logic [W-1:0] arith_sum, logic_res;
  logic         arith_c, arith_v;

  dp_alu_arith #(.W(W)) u_arith (
    .opc_i(opc_i), .a_i(opa_i), .b_i(opb_i), .cin_i(flg_i[FC]),
    .sum_o(arith_sum), .c_o(arith_c), .v_o(arith_v)
  );

  dp_alu_logic #(.W(W)) u_logic (
    .opc_i(opc_i), .a_i(opa_i), .b_i(opb_i), .r_o(logic_res)
  );

  assign res_o = op_is_arith(opc_i) ? arith_sum : logic_res;

  dp_alu_flags #(.W(W)) u_flags (
    .opc_i(opc_i), .res_i(res_o), .ac_i(arith_c), .av_i(arith_v),
    .shc_i(shc_i), .flg_i(flg_i), .setf_i(setf_i), .rd_pc_i(rd_pc_i),
    .flg_o(flg_o), .wr_en_o(wr_en_o), .rstr_o(rstr_o), .undef_o(undef_o)
  );

  always_comb begin
    if (!$isunknown({opc_i, flg_i, setf_i, rd_pc_i, opa_i, opb_i, shc_i})) begin
      p_zero_flag_r5: assert (!(flg_o != flg_i && flg_o[FZ]) || res_o == '0)
        else $error("Z set on nonzero result");
    end
  end
endmodule

// File: tb/sim_dp_alu.sv
module sim_dp_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opc;
  logic [31:0] opa, opb;
  logic        shc, setf, rdpc;
  logic [3:0]  flg;
  logic [31:0] res;
  logic        wen, rstr, undf;
  logic [3:0]  flgo;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  dp_alu u0 (
    .opc_i(opc), .opa_i(opa), .opb_i(opb), .shc_i(shc), .flg_i(flg),
    .setf_i(setf), .rd_pc_i(rdpc), .res_o(res), .wr_en_o(wen),
    .flg_o(flgo), .rstr_o(rstr), .undef_o(undf)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s op=%0h a=%h b=%h act=%h exp=%h", tag, opc, opa, opb, act, exp);
    end
  endtask

  task automatic run(input int o, input logic [31:0] a, input logic [31:0] b,
                     input logic [3:0] f, input bit sc, input bit sf, input bit pc);
    longint x, y, s, ci, lim, r;
    bit     isarith, istest, issub, calc, en, vv, cc;
    logic [31:0] r32;
    logic [3:0] ef;
    @(posedge clk); #1;
    opc = o[3:0]; opa = a; opb = b; flg = f; shc = sc; setf = sf; rdpc = pc;
    lim = 64'h1_0000_0000;
    istest  = (o >= 8 && o <= 11);
    isarith = (o >= 2 && o <= 7) || o == 10 || o == 11;
    issub   = (o == 2 || o == 3 || o == 6 || o == 7 || o == 10);
    x = (o == 3 || o == 7) ? longint'(b) : longint'(a);
    y = (o == 3 || o == 7) ? longint'(a) : longint'(b);
    ci = (o == 5 || o == 6 || o == 7) ? longint'(f[1]) : 0;
    cc = 0; vv = 0; r = 0;
    case (o)
      0, 8: r = a & b;
      1, 9: r = a ^ b;
      12: r = a | b;
      13: r = b;
      14: r = a & ~b;
      15: r = ~b;
      default: begin
        if (issub) begin
          if (o == 2 || o == 3 || o == 10) ci = 1;
          s = y + 1 - ci;
          r = (x - s) & (lim - 1);
          cc = (s <= x);
        end else begin
          s = x + y + ci;
          r = s & (lim - 1);
          cc = (s >= lim);
        end
      end
    endcase
    r32 = r[31:0];
    if (isarith) begin
      if (issub) vv = (x[31] != y[31]) && (r32[31] != x[31]);
      else       vv = (x[31] == y[31]) && (r32[31] != x[31]);
    end
    calc = istest ? !pc : (sf && !pc);
    ef = f;
    if (calc) begin
      ef[3] = r32[31];
      ef[2] = (r32 == 0);
      ef[1] = isarith ? cc : sc;
    if (isarith) ef[0] = vv;
    end
    en = !istest;
    @(negedge clk);
    if (!istest) chk(res === r32, isarith ? "R2 result" : "R1 result", res, r32);
    chk(wen === en, "R7 write enable", wen, en);
    if (istest && pc) begin
      chk(undf === 1'b1 && rstr === 1'b0, "R10 undef", {undf, rstr}, 2'b10);
      chk(flgo === f, "R10 flags held", flgo, f);
    end else if (!istest && sf && pc) begin
      chk(rstr === 1'b1 && undf === 1'b0, "R9 restore", {rstr, undf}, 2'b10);
      chk(flgo === f, "R9 flags held", flgo, f);
    end else begin
      chk(rstr === 1'b0 && undf === 1'b0, "R11 quiet", {rstr, undf}, 0);
      if (!calc) chk(flgo === f, "R8 flags held", flgo, f);
      else begin
        chk(flgo[3:2] === ef[3:2], "R5 NZ", flgo[3:2], ef[3:2]);
        chk(flgo[1] === ef[1], isarith ? "R3 carry" : "R6 carry", flgo[1], ef[1]);
        chk(flgo[0] === ef[0], isarith ? "R4 overflow" : "R6 V kept", flgo[0], ef[0]);
      end
    end
  endtask

  initial begin
    logic [31:0] cv [5];
    cv[0] = 32'h0; cv[1] = 32'hFFFF_FFFF; cv[2] = 32'h7FFF_FFFF;
    cv[3] = 32'h8000_0000; cv[4] = 32'h1;
    opc = 0; opa = 0; opb = 0; flg = 0; shc = 0; setf = 0; rdpc = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(res === 32'h0 && wen === 1'b1 && flgo === 4'h0 && rstr === 1'b0 && undf === 1'b0,
        "R8 reset state", {res, wen, flgo}, 37'h1_0);
    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          for (int k = 0; k < 2; k++) begin
            run(o, cv[i], cv[j], {2'b01, k[0], 1'b1}, k[0], 1'b1, 1'b0);
          end
        end
      end
      for (int n = 0; n < 60; n++) begin
        run(o, $urandom, $urandom, 4'($urandom), 1'($urandom),
            1'($urandom), ($urandom % 4) == 0);
      end
      run(o, 32'h5, 32'h5, 4'b0000, 1'b0, 1'b0, 1'b0);
      run(o, 32'h5, 32'h5, 4'b1011, 1'b1, 1'b1, 1'b1);
      run(o, 32'h5, 32'h5, 4'b0100, 1'b1, 1'b0, 1'b1);
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule